// File: doc/BRIEF.md
# Multi-Cycle 32-bit Load/Store Processor

This block is a small 32-bit processor core that runs each instruction over several clock cycles. It supports five kinds of instruction: word load, word store, register-to-register arithmetic and logic (add, subtract, and, or, signed set-less-than), branch-if-equal and an absolute jump. A finite-state controller sequences each instruction. The controller reuses one memory port and one ALU in different cycles, so that a single adder serves the program-counter increment, the effective-address computation and the branch target.

Instruction words and data words share one memory port. That port has an address, write data, read data, a read enable and a write enable. Read data must be valid in the same cycle that the address is presented, and a write takes effect at the clock edge that ends the cycle. Between cycles, state is held in internal holding registers: the instruction word, the memory data word, the two register operands and the ALU result.

Top module: `mcp_core`

## Requirements
- R1: Reset is asynchronous and active low. While reset is held, the write enable stays low. After release, the first fetch reads address 0.
- R2: Every instruction begins with a fetch cycle. In that cycle the read enable is high and the memory address equals the program counter.
- R3: The next fetch follows immediately after the last cycle of the current instruction. Instruction lengths are: load 5 cycles, store 4, register op 4, branch 3, jump 3, and any other opcode 2.
- R4: Load has opcode bits[31:26] = 0x23. In its 4th cycle it reads memory at reg[bits 25:21] + sign-extended bits[15:0]. The word read is written into register bits[20:16].
- R5: Store has opcode 0x2B. In its 4th cycle the write enable is high, the address is reg[bits 25:21] + sign-extended bits[15:0], and the write data is reg[bits 20:16].
- R6: A register op has opcode 0x00. Its funct field, bits[5:0], selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). The operands are reg[25:21] and reg[20:16], and the result goes to register bits[15:11].
- R7: Register 0 always reads as zero. Writes to register 0 are discarded.
- R8: Branch has opcode 0x04. If the two registers are equal, the next PC is PC+4 + (sign-extended bits[15:0] shifted left 2). Otherwise the next PC is PC+4.
- R9: Jump has opcode 0x02. The next PC is the upper 4 bits of PC+4, followed by bits[25:0], followed by two zero bits.
- R10: Any other opcode writes neither a register nor memory, and the next PC is PC+4.
- R11: The write enable is high only in the 4th cycle of a store. The read enable and the write enable are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Memory word address (byte addressed) |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read enable |
| mem_wr | output | 1 | Write enable |

## Verification
The bench builds the core with its defaults: a 32-bit data path and 32 registers. With these values the jump concatenation keeps real upper PC bits, and a random register index hits register 0 about one time in 32. Branch offsets and load/store addresses span the full 32-bit range. The bench memory decodes only ten word-address bits, so far-flung PCs and addresses still land on real storage. A reference model, stepped one instruction at a time, predicts every fetch address, every data access cycle and every store. A register op's results become visible through later stores and branch outcomes.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam int OPW = 6;
    localparam int RIW = 5;
    localparam int IMW = 16;
    localparam int JIW = 26;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_JUMP  = 6'h02;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPW-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPW-1:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // operand-B select and next-PC select codes
    localparam logic [1:0] SB_REG  = 2'b00;
    localparam logic [1:0] SB_FOUR = 2'b01;
    localparam logic [1:0] SB_IMM  = 2'b10;
    localparam logic [1:0] SB_IMM4 = 2'b11;
    localparam logic [1:0] PS_ALU  = 2'b00;
    localparam logic [1:0] PS_RES  = 2'b01;
    localparam logic [1:0] PS_JMP  = 2'b10;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_ADDR, S_LDRD, S_LDWB,
        S_STWR, S_REXE, S_RWB, S_BRCH, S_JUMP
    } state_e;

    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNCT = 2'b10
    } alu_mode_e;

    typedef enum logic [2:0] {
        AF_ADD, AF_SUB, AF_AND, AF_OR, AF_SLT
    } alu_fn_e;

    typedef struct packed {
        logic       pc_we;
        logic       pc_we_zero;
        logic       addr_res;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_we;
        logic       rf_we;
        logic       rf_dst_rd;
        logic       rf_from_mem;
        logic       srca_reg;
        logic [1:0] srcb_sel;
        logic [1:0] pc_sel;
        alu_mode_e  alu_mode;
    } ctrl_t;

endpackage

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
    import mcp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    output ctrl_t          ctl,
    output state_e         state_o
);

    state_e st_d, st_q;

    always_comb begin
        st_d         = st_q;
        ctl          = '0;
        ctl.alu_mode = AM_ADD;
        ctl.srcb_sel = SB_REG;
        ctl.pc_sel   = PS_ALU;
        case (st_q)
            S_FETCH: begin
                ctl.mem_rd   = 1'b1;
                ctl.instr_we = 1'b1;
                ctl.srcb_sel = SB_FOUR;
                ctl.pc_sel   = PS_ALU;
                ctl.pc_we    = 1'b1;
                st_d         = S_DECODE;
            end
            S_DECODE: begin
                ctl.srcb_sel = SB_IMM4;
                case (opcode)
                    OP_LOAD, OP_STORE: st_d = S_ADDR;
                    OP_RTYPE:          st_d = S_REXE;
                    OP_BEQ:            st_d = S_BRCH;
                    OP_JUMP:           st_d = S_JUMP;
                    default:           st_d = S_FETCH;
                endcase
            end
            S_ADDR: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb_sel = SB_IMM;
                st_d         = (opcode == OP_STORE) ? S_STWR : S_LDRD;
            end
            S_LDRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_res = 1'b1;
                st_d         = S_LDWB;
            end
            S_LDWB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_from_mem = 1'b1;
                st_d            = S_FETCH;
            end
            S_STWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_res = 1'b1;
                st_d         = S_FETCH;
            end
            S_REXE: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb_sel = SB_REG;
                ctl.alu_mode = AM_FUNCT;
                st_d         = S_RWB;
            end
            S_RWB: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
                st_d          = S_FETCH;
            end
            S_BRCH: begin
                ctl.srca_reg   = 1'b1;
                ctl.srcb_sel   = SB_REG;
                ctl.alu_mode   = AM_SUB;
                ctl.pc_we_zero = 1'b1;
                ctl.pc_sel     = PS_RES;
                st_d           = S_FETCH;
            end
            S_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_sel = PS_JMP;
                st_d       = S_FETCH;
            end
            default: st_d = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_FETCH;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/mcp_alu.sv
module mcp_alu
    import mcp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_mode_e       mode,
    input  logic [5:0]      funct,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    alu_fn_e fn;

    always_comb begin
        case (mode)
            AM_SUB:   fn = AF_SUB;
            AM_FUNCT: begin
                case (funct)
                    FN_SUB:  fn = AF_SUB;
                    FN_AND:  fn = AF_AND;
                    FN_OR:   fn = AF_OR;
                    FN_SLT:  fn = AF_SLT;
                    default: fn = AF_ADD;
                endcase
            end
            default:  fn = AF_ADD;
        endcase
    end

    always_comb begin
        case (fn)
            AF_SUB:  y = a - b;
            AF_AND:  y = a & b;
            AF_OR:   y = a | b;
            AF_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) regs_d[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

endmodule

// File: rtl/mcp_core.sv
module mcp_core
    import mcp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_rd,
    output logic            mem_wr
);

    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] mdata;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
    } dp_t;

    dp_t             dp_d, dp_q;
    ctrl_t           ctl;
    state_e          ctl_state;
    logic [XLEN-1:0] imm_ext, srca, srcb, alu_y, rf_rd1, rf_rd2, rf_wd, jmp_tgt;
    logic            alu_zero;
    logic [AW-1:0]   rf_wa;

    mcp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (dp_q.instr[31:26]),
        .ctl     (ctl),
        .state_o (ctl_state)
    );

    mcp_alu #(.XLEN(XLEN)) u_alu (
        .a     (srca),
        .b     (srcb),
        .mode  (ctl.alu_mode),
        .funct (dp_q.instr[5:0]),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    mcp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (dp_q.instr[25:21]),
        .ra2   (dp_q.instr[20:16]),
        .we    (ctl.rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2)
    );

    always_comb begin
        imm_ext = {{(XLEN-IMW){dp_q.instr[IMW-1]}}, dp_q.instr[IMW-1:0]};
        jmp_tgt = {dp_q.pc[XLEN-1:JIW+2], dp_q.instr[JIW-1:0], 2'b00};
        srca    = ctl.srca_reg ? dp_q.opa : dp_q.pc;
        case (ctl.srcb_sel)
            SB_FOUR: srcb = XLEN'(4);
            SB_IMM:  srcb = imm_ext;
            SB_IMM4: srcb = imm_ext << 2;
            default: srcb = dp_q.opb;
        endcase
        rf_wa = ctl.rf_dst_rd ? dp_q.instr[15:11] : dp_q.instr[20:16];
        rf_wd = ctl.rf_from_mem ? dp_q.mdata : dp_q.res;
    end

    always_comb begin
        dp_d       = dp_q;
        dp_d.mdata = mem_rdata;
        dp_d.opa   = rf_rd1;
        dp_d.opb   = rf_rd2;
        dp_d.res   = alu_y;
        if (ctl.instr_we) dp_d.instr = mem_rdata;
        if (ctl.pc_we || (ctl.pc_we_zero && alu_zero)) begin
            case (ctl.pc_sel)
                PS_RES:  dp_d.pc = dp_q.res;
                PS_JMP:  dp_d.pc = jmp_tgt;
                default: dp_d.pc = alu_y;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_addr  = ctl.addr_res ? dp_q.res : dp_q.pc;
    assign mem_wdata = dp_q.opb;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/mcp_core_chk.sv
module mcp_core_chk
    import mcp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [XLEN-1:0] mem_addr,
    input state_e          state,
    input logic [XLEN-1:0] pc
);

    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && state == S_FETCH));

    assert_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |-> (mem_rd && mem_addr == pc));

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_FETCH && state != S_BRCH && state != S_JUMP) |=> $stable(pc));

    assert_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LDWB || state == S_STWR || state == S_RWB ||
         state == S_BRCH || state == S_JUMP) |=> (state == S_FETCH));

    assert_load_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LDRD) |=> (state == S_LDWB));

    assert_wr_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (state == S_STWR));

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind mcp_core mcp_core_chk #(.XLEN(XLEN)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .state    (ctl_state),
    .pc       (dp_q.pc)
);

// File: tb/test_mcp_core.sv
`timescale 1ns/1ps
module test_mcp_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;

    always #2 clk = ~clk;

    mcp_core i_mcp_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    logic [31:0] mem [1024];
    logic [31:0] mm  [1024];
    logic [31:0] mreg [32];
    logic [31:0] pc_m;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string prev_tag = "R1";

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] i);
        return {{16{i[15]}}, i};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] rop(input logic [5:0] fn, input logic [31:0] a, b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    function automatic logic [31:0] gen_instr();
        logic [4:0] rs, rt, rd;
        logic [5:0] fns [5];
        int kind;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        rs = 5'($urandom % 32); rt = 5'($urandom % 32); rd = 5'($urandom % 32);
        kind = int'($urandom % 16);
        if (kind < 4)       return enc_i(6'h23, rs, rt, 16'($urandom));
        else if (kind < 7)  return enc_i(6'h2B, rs, rt, 16'($urandom));
        else if (kind < 12) return enc_r(rs, rt, rd, fns[$urandom % 5]);
        else if (kind < 14) return enc_i(6'h04, rs, ($urandom % 2 == 0) ? rs : rt, 16'($urandom));
        else if (kind == 14) return {6'h02, 26'($urandom)};
        else                return {(($urandom % 2 == 0) ? 6'h3F : 6'h0D), 26'($urandom)};
    endfunction

    // one instruction: fetch check, per-cycle bus checks, model update
    task automatic run_instr(input logic [31:0] ins, input string xtag);
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd;
        logic [31:0] ea, sdat, ldat, nxt, pc4;
        int          ncyc;
        string       tag;
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        @(negedge clk);
        mem[pc_m[11:2]] = ins;
        mm[pc_m[11:2]]  = ins;
        chk(mem_rd === 1'b1 && mem_wr === 1'b0 && mem_addr === pc_m,
            {"R2 R3 fetch address/cycle after ", prev_tag}, mem_addr, pc_m);
        ea   = mreg[rs] + sx(ins[15:0]);
        sdat = mreg[rt];
        ldat = mm[ea[11:2]];
        pc4  = pc_m + 32'd4;
        nxt  = pc4;
        case (op)
            6'h23: begin ncyc = 5; tag = "R4"; end
            6'h2B: begin ncyc = 4; tag = "R5"; end
            6'h00: begin ncyc = 4; tag = "R6"; end
            6'h04: begin
                ncyc = 3; tag = "R8";
                if (mreg[rs] == mreg[rt]) nxt = pc4 + (sx(ins[15:0]) << 2);
            end
            6'h02: begin ncyc = 3; tag = "R9"; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
            default: begin ncyc = 2; tag = "R10"; end
        endcase
        if (xtag != "") tag = {tag, " ", xtag};
        for (int k = 1; k < ncyc; k++) begin
            @(negedge clk);
            if (k == 3 && op == 6'h23) begin
                chk(mem_rd === 1'b1 && mem_wr === 1'b0 && mem_addr === ea,
                    {"R4 load address ", tag}, mem_addr, ea);
            end else if (k == 3 && op == 6'h2B) begin
                chk(mem_wr === 1'b1 && mem_rd === 1'b0 && mem_addr === ea,
                    {"R5 store address ", tag}, mem_addr, ea);
                chk(mem_wdata === sdat, {"R5 store data ", tag}, mem_wdata, sdat);
            end else begin
                chk(mem_wr === 1'b0, {"R11 no stray write ", tag}, {31'd0, mem_wr}, 32'd0);
            end
        end
        case (op)
            6'h23: if (rt != 5'd0) mreg[rt] = ldat;
            6'h2B: mm[ea[11:2]] = sdat;
            6'h00: if (rd != 5'd0) mreg[rd] = rop(ins[5:0], mreg[rs], mreg[rt]);
            default: ;
        endcase
        pc_m     = nxt;
        prev_tag = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = $urandom;
            mm[i]  = mem[i];
        end
        mem[32'h100 >> 2] = 32'h8000_0001; mm[32'h100 >> 2] = 32'h8000_0001;
        mem[32'h104 >> 2] = 32'h0000_0005; mm[32'h104 >> 2] = 32'h0000_0005;
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        pc_m = 32'd0;

        // R1: no write while held in reset
        repeat (3) begin
            @(negedge clk);
            chk(mem_wr === 1'b0, "R1 write enable low in reset", {31'd0, mem_wr}, 32'd0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // directed corners
        run_instr(enc_i(6'h23, 5'd0, 5'd1, 16'h0100), "");
        run_instr(enc_i(6'h23, 5'd0, 5'd2, 16'h0104), "");
        run_instr(enc_r(5'd1, 5'd2, 5'd3, 6'h2A), "signed slt");
        run_instr(enc_i(6'h2B, 5'd0, 5'd3, 16'h0200), "R6 slt result");
        run_instr(enc_r(5'd1, 5'd2, 5'd0, 6'h20), "R7 write to r0");
        run_instr(enc_i(6'h2B, 5'd0, 5'd0, 16'h0204), "R7 r0 reads zero");
        run_instr(enc_r(5'd2, 5'd2, 5'd4, 6'h22), "");
        run_instr(enc_i(6'h04, 5'd4, 5'd0, 16'h0003), "taken forward");
        run_instr(enc_i(6'h04, 5'd1, 5'd2, 16'hFFFE), "not taken");
        run_instr(enc_r(5'd1, 5'd2, 5'd5, 6'h24), "");
        run_instr(enc_r(5'd1, 5'd2, 5'd6, 6'h25), "");
        run_instr(enc_i(6'h2B, 5'd0, 5'd5, 16'h0208), "R6 and result");
        run_instr(enc_i(6'h2B, 5'd0, 5'd6, 16'h020C), "R6 or result");
        run_instr(enc_i(6'h04, 5'd3, 5'd3, 16'hFFF0), "taken backward");
        run_instr({6'h3F, 26'h155_5555}, "unknown opcode");
        run_instr({6'h02, 26'h000_0040}, "jump");

        // constrained random stream
        for (int n = 0; n < 500; n++) run_instr(gen_instr(), "");
        @(negedge clk);
        chk(mem_rd === 1'b1 && mem_addr === pc_m,
            {"R2 R3 final fetch after ", prev_tag}, mem_addr, pc_m);

        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i]) bad++;
            chk(bad == 0, "R5 R7 final memory image", bad, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule